// File: doc/BRIEF.md
# Speech Port Controller

This block sits on a byte-wide I/O bus and gives a processor a control byte, a status byte and two 16-byte speech FIFOs. The control register is written and the status register is read at one port address. Speech bytes to the outgoing FIFO and from the incoming FIFO share a second port address. Two further port addresses act as strobes: one resets the whole controller, the other acknowledges a pending speech interrupt.

A frame tick paces the speech stream. With loopback selected, each tick moves at most one byte from the outgoing FIFO into the incoming FIFO. Without loopback, each tick hands one outgoing byte to the codec side, and bytes from the codec enter the incoming FIFO. An active-low interrupt request is raised from one of three selectable sources: the serial port's receive-ready flag, a speech DMA end-count pulse, or the speech FIFO condition. The serial port's ready flags come in as pins and are shown in the status byte.

Top module: `spk_ctrl`

## Requirements
- R1: Writing address 0xC0 loads the control byte. Control bit 7 is speech-in enable, bit 6 speech-out enable, bit 5 frame sync, bit 4 loopback, and bits 1:0 the interrupt source. A read of 0xC0 returns status bit 5 = speech-in enable, bit 4 = speech-out enable, bit 1 = source bit 1 and bit 0 = source bit 0.
- R2: Control bits 3:2 drive `baud_sel` directly (0 = 300, 1 = 600, 2 = 1200, 3 = 2400 baud).
- R3: Status bit 3 reads 0 exactly when the incoming FIFO holds a byte. Status bit 2 reads 0 exactly when the outgoing FIFO has room.
- R4: Status bit 7 is the inverse of `uart_rx_rdy` and status bit 6 is the inverse of `uart_tx_rdy`.
- R5: A write to 0xC1 enters the outgoing FIFO only while speech-out is enabled and the FIFO holds fewer than 16 bytes. Any other such write is dropped.
- R6: With loopback, frame sync, speech-in and speech-out all set, each frame tick moves one byte from the outgoing FIFO to the incoming FIFO, in order and with no loss. With frame sync clear, no byte moves.
- R7: Without loopback, with speech-out and frame sync set, each frame tick presents the oldest outgoing byte on `spk_out_data` with `spk_out_vld` high for that cycle. A `spk_in_vld` pulse with speech-in enabled enters `spk_in_data` into the incoming FIFO.
- R8: Interrupt sources are 00 = serial receive-ready, 10 = DMA end-count pulse, 11 = speech FIFO (a byte is waiting in an enabled incoming FIFO, or an enabled outgoing FIFO has room). A rising source condition, or a `dma_done` pulse with the DMA source selected, drives `irq_n` low one clock later.
- R9: A write to 0xC3 releases `irq_n` on the next clock. It stays released until the condition falls and rises again. A level source that goes away also releases `irq_n`. A DMA request is held until it is acknowledged.
- R10: A write to 0xC2 clears the control byte. A write to 0xC2, or a write of 0x00 to 0xC0, empties both FIFOs and releases `irq_n`.
- R11: A read of 0xC1 removes the oldest incoming byte. When the incoming FIFO is empty the read returns 0x00 and has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 8 | I/O port address |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from address |
| frame_tick | input | 1 | Frame pacing pulse |
| spk_in_vld | input | 1 | Codec byte valid |
| spk_in_data | input | 8 | Codec byte |
| spk_out_vld | output | 1 | Outgoing byte valid to codec |
| spk_out_data | output | 8 | Outgoing byte to codec |
| uart_rx_rdy | input | 1 | Serial receiver has a byte |
| uart_tx_rdy | input | 1 | Serial transmitter can take a byte |
| dma_done | input | 1 | Speech DMA end-count pulse |
| baud_sel | output | 2 | Serial rate select |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
The bound checker watches several rules on every cycle. Neither FIFO ever counts past its depth. The incoming FIFO never gains more than one byte in a cycle. A control write shows up in the status echo on the next cycle. An acknowledge, a controller reset or a zero control write always leaves `irq_n` high with empty FIFOs. A DMA pulse on the DMA source always raises the request. Byte order through loopback and through the codec path, the drop of overflow and disabled writes, the frame-sync gate, and the difference between edge-set and level-cleared requests can only be shown by the bench's scenarios. A scoreboard queue of expected bytes supports those checks.

// File: rtl/spk_pkg.sv
package spk_pkg;

  localparam logic [7:0] ADDR_CTRL = 8'hC0;
  localparam logic [7:0] ADDR_DATA = 8'hC1;
  localparam logic [7:0] ADDR_RST  = 8'hC2;
  localparam logic [7:0] ADDR_ACK  = 8'hC3;

  typedef enum logic [1:0] {
    SRC_SERIAL = 2'b00,
    SRC_RSVD   = 2'b01,
    SRC_DMA    = 2'b10,
    SRC_FIFO   = 2'b11
  } irq_src_e;

  // bit order matters: it is the control byte layout
  typedef struct packed {
    logic       in_en;
    logic       out_en;
    logic       fsync;
    logic       loop;
    logic [1:0] baud;
    irq_src_e   src;
  } ctrl_t;

  // status: uart flags and fifo flags active low, selections echoed
  function automatic logic [7:0] pack_status(ctrl_t c, logic rx_rdy, logic tx_rdy,
                                             logic in_has, logic out_room);
    return {~rx_rdy, ~tx_rdy, c.in_en, c.out_en, ~in_has, ~out_room,
            c.src[1], c.src[0]};
  endfunction

  function automatic logic loop_go(ctrl_t c, logic tick, logic out_has, logic in_room);
    return tick && c.fsync && c.loop && c.in_en && c.out_en && out_has && in_room;
  endfunction

  function automatic logic codec_go(ctrl_t c, logic tick, logic out_has);
    return tick && c.fsync && !c.loop && c.out_en && out_has;
  endfunction

endpackage

// File: rtl/spk_fifo.sv
module spk_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 16,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic [W-1:0]  dout,
  output logic [CW-1:0] cnt
);

  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          push_ok, pop_ok;

  function automatic logic [AW-1:0] next_ptr(logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign push_ok = push && (cnt != CW'(DEPTH));
  assign pop_ok  = pop && (cnt != '0);
  assign dout    = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push_ok && !flush) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else if (flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (push_ok) wr_ptr <= next_ptr(wr_ptr);
      if (pop_ok)  rd_ptr <= next_ptr(rd_ptr);
      case ({push_ok, pop_ok})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

endmodule

// File: rtl/spk_regs.sv
module spk_regs
  import spk_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_wr,
  input  logic [7:0] bus_addr,
  input  logic [7:0] bus_wdata,
  output ctrl_t      ctrl,
  output logic       clear_all,
  output logic       ack_wr,
  output logic       data_wr
);

  logic ctrl_wr, rst_wr;

  assign ctrl_wr   = bus_wr && (bus_addr == ADDR_CTRL);
  assign rst_wr    = bus_wr && (bus_addr == ADDR_RST);
  assign ack_wr    = bus_wr && (bus_addr == ADDR_ACK);
  assign data_wr   = bus_wr && (bus_addr == ADDR_DATA);
  assign clear_all = rst_wr || (ctrl_wr && (bus_wdata == 8'h00));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl <= '0;
    else if (rst_wr)  ctrl <= '0;
    else if (ctrl_wr) ctrl <= ctrl_t'(bus_wdata);
  end

endmodule

// File: rtl/spk_irq.sv
module spk_irq
  import spk_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  irq_src_e src,
  input  logic     uart_rx_rdy,
  input  logic     dma_done,
  input  logic     fifo_cond,
  input  logic     ack,
  input  logic     clear_all,
  output logic     irq_n
);

  logic cond, cond_q, level_src, dma_set, pend;

  always_comb begin
    case (src)
      SRC_SERIAL: cond = uart_rx_rdy;
      SRC_FIFO:   cond = fifo_cond;
      default:    cond = 1'b0;
    endcase
  end

  assign level_src = (src == SRC_SERIAL) || (src == SRC_FIFO);
  assign dma_set   = (src == SRC_DMA) && dma_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend   <= 1'b0;
      cond_q <= 1'b1;
    end else if (clear_all) begin
      pend   <= 1'b0;
      cond_q <= 1'b1;
    end else begin
      cond_q <= cond;
      if (ack)                                pend <= 1'b0;
      else if ((cond && !cond_q) || dma_set)  pend <= 1'b1;
      else if (level_src && !cond)            pend <= 1'b0;
    end
  end

  assign irq_n = ~pend;

endmodule

// File: rtl/spk_ctrl.sv
module spk_ctrl
  import spk_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] bus_addr,
  input  logic       bus_wr,
  input  logic       bus_rd,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  input  logic       frame_tick,
  input  logic       spk_in_vld,
  input  logic [7:0] spk_in_data,
  output logic       spk_out_vld,
  output logic [7:0] spk_out_data,
  input  logic       uart_rx_rdy,
  input  logic       uart_tx_rdy,
  input  logic       dma_done,
  output logic [1:0] baud_sel,
  output logic       irq_n
);

  ctrl_t       ctrl;
  logic        clear_all, ack_wr, data_wr;
  logic [CW-1:0] in_cnt, out_cnt;
  logic [7:0]  in_dout, out_dout, in_din, status_byte;
  logic        in_has, in_room, out_has, out_room;
  logic        loop_move, codec_move, in_push, in_pop, out_push, out_pop;
  logic        fifo_cond;
  logic [1:0]  src_sel;

  spk_regs u_regs (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .ctrl(ctrl), .clear_all(clear_all),
    .ack_wr(ack_wr), .data_wr(data_wr)
  );

  assign in_has   = (in_cnt != '0);
  assign in_room  = (in_cnt != CW'(DEPTH));
  assign out_has  = (out_cnt != '0);
  assign out_room = (out_cnt != CW'(DEPTH));

  assign loop_move  = loop_go(ctrl, frame_tick, out_has, in_room);
  assign codec_move = codec_go(ctrl, frame_tick, out_has);

  assign out_push = data_wr && ctrl.out_en;
  assign out_pop  = loop_move || codec_move;
  assign in_push  = loop_move || (spk_in_vld && ctrl.in_en && !ctrl.loop);
  assign in_din   = loop_move ? out_dout : spk_in_data;
  assign in_pop   = bus_rd && (bus_addr == ADDR_DATA);

  spk_fifo #(.W(8), .DEPTH(DEPTH), .CW(CW)) u_out_fifo (
    .clk(clk), .rst_n(rst_n), .flush(clear_all), .push(out_push),
    .din(bus_wdata), .pop(out_pop), .dout(out_dout), .cnt(out_cnt)
  );

  spk_fifo #(.W(8), .DEPTH(DEPTH), .CW(CW)) u_in_fifo (
    .clk(clk), .rst_n(rst_n), .flush(clear_all), .push(in_push),
    .din(in_din), .pop(in_pop), .dout(in_dout), .cnt(in_cnt)
  );

  assign fifo_cond = (ctrl.in_en && in_has) || (ctrl.out_en && out_room);
  assign src_sel   = ctrl.src;

  spk_irq u_irq (
    .clk(clk), .rst_n(rst_n), .src(ctrl.src), .uart_rx_rdy(uart_rx_rdy),
    .dma_done(dma_done), .fifo_cond(fifo_cond), .ack(ack_wr),
    .clear_all(clear_all), .irq_n(irq_n)
  );

  assign status_byte = pack_status(ctrl, uart_rx_rdy, uart_tx_rdy, in_has, out_room);

  always_comb begin
    if (bus_addr == ADDR_CTRL)      bus_rdata = status_byte;
    else if (bus_addr == ADDR_DATA) bus_rdata = in_has ? in_dout : 8'h00;
    else                            bus_rdata = 8'h00;
  end

  assign spk_out_vld  = codec_move;
  assign spk_out_data = out_dout;
  assign baud_sel     = ctrl.baud;

endmodule

// File: rtl/spk_ctrl_chk.sv
module spk_ctrl_chk #(
  parameter int DEPTH = 16,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_wr,
  input logic [7:0]    bus_addr,
  input logic [7:0]    bus_wdata,
  input logic          dma_done,
  input logic          irq_n,
  input logic [7:0]    status_byte,
  input logic [CW-1:0] in_cnt,
  input logic [CW-1:0] out_cnt,
  input logic [1:0]    src_sel,
  input logic          clear_all
);

  // R5
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_cnt <= CW'(DEPTH)) && (in_cnt <= CW'(DEPTH)));

  // R6
  one_per_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ({1'b0, in_cnt} <= {1'b0, $past(in_cnt)} + 1'b1));

  // R1
  ctrl_echo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 8'hC0) |=>
      (status_byte[5:4] == $past(bus_wdata[7:6]) &&
       status_byte[1:0] == $past(bus_wdata[1:0])));

  // R10
  flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear_all |=> (in_cnt == '0 && out_cnt == '0 && irq_n));

  // R9
  ack_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 8'hC3) |=> irq_n);

  // R8
  dma_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_done && src_sel == 2'b10 && !clear_all &&
     !(bus_wr && bus_addr == 8'hC3)) |=> !irq_n);

endmodule

bind spk_ctrl spk_ctrl_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .dma_done(dma_done), .irq_n(irq_n),
  .status_byte(status_byte), .in_cnt(in_cnt), .out_cnt(out_cnt),
  .src_sel(src_sel), .clear_all(clear_all)
);

// File: tb/tb_spk_ctrl.sv
module tb_spk_ctrl;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rst_n = 1'b0;
  logic [7:0] bus_addr = 8'h00, bus_wdata = 8'h00, bus_rdata;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic       frame_tick = 1'b0, spk_in_vld = 1'b0;
  logic [7:0] spk_in_data = 8'h00, spk_out_data;
  logic       spk_out_vld;
  logic       uart_rx_rdy = 1'b0, uart_tx_rdy = 1'b0, dma_done = 1'b0;
  logic [1:0] baud_sel;
  logic       irq_n;

  spk_ctrl dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .frame_tick(frame_tick), .spk_in_vld(spk_in_vld), .spk_in_data(spk_in_data),
    .spk_out_vld(spk_out_vld), .spk_out_data(spk_out_data),
    .uart_rx_rdy(uart_rx_rdy), .uart_tx_rdy(uart_tx_rdy), .dma_done(dma_done),
    .baud_sel(baud_sel), .irq_n(irq_n)
  );

  int checks = 0, fails = 0, out_seen = 0;
  logic [7:0] exp_q[$];
  logic [7:0] v;

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  // expected status restated from R1, R3, R4
  function automatic logic [7:0] exp_status(logic [7:0] c, logic rx, logic tx,
                                            logic in_has, logic out_room);
    logic [7:0] s;
    s = 8'h00;
    s[7] = !rx;  s[6] = !tx;
    s[5] = c[7]; s[4] = c[6];
    s[3] = !in_has; s[2] = !out_room;
    s[1] = c[1]; s[0] = c[0];
    return s;
  endfunction

  task automatic wr(logic [7:0] a, logic [7:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [7:0] d);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk); bus_rd = 1'b0;
  endtask

  task automatic tick();
    @(negedge clk); frame_tick = 1'b1;
    @(negedge clk); frame_tick = 1'b0;
  endtask

  // driver: every accepted outgoing byte becomes an expected item
  task automatic push_out(logic [7:0] d);
    wr(8'hC1, d);
    exp_q.push_back(d);
  endtask

  task automatic pop_in(string req);
    logic [7:0] got;
    rd(8'hC1, got);
    if (exp_q.size() == 0) check(req, got, 8'hxx);
    else check(req, got, exp_q.pop_front());
  endtask

  // monitor for the codec side
  initial begin
    forever begin
      @(negedge clk); #2;
      if (spk_out_vld) begin
        out_seen++;
        if (exp_q.size() == 0) begin
          checks++; fails++;
          $display("FAIL R7 actual=%02h expected=none", spk_out_data);
        end else check("R7", spk_out_data, exp_q.pop_front());
      end
    end
  end

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(20 * 200000);
    checks++; fails++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // reset state (R10)
    rd(8'hC0, v);
    check("R10 reset status", v, exp_status(8'h00, 0, 0, 0, 1));
    check("R10 reset irq", {7'b0, irq_n}, 8'h01);

    // R2 baud select
    wr(8'hC0, 8'h0C);
    check("R2 baud", {6'b0, baud_sel}, 8'h03);
    wr(8'hC0, 8'h08);
    check("R2 baud", {6'b0, baud_sel}, 8'h02);

    // R1 echo
    wr(8'hC0, 8'hF3);
    rd(8'hC0, v);
    check("R1 echo", v, exp_status(8'hF3, 0, 0, 0, 1));
    wr(8'hC0, 8'h00);

    // R4 serial ready flags
    @(negedge clk); uart_rx_rdy = 1'b1;
    rd(8'hC0, v);
    check("R4 rx flag", v, exp_status(8'h00, 1, 0, 0, 1));
    @(negedge clk); uart_rx_rdy = 1'b0; uart_tx_rdy = 1'b1;
    rd(8'hC0, v);
    check("R4 tx flag", v, exp_status(8'h00, 0, 1, 0, 1));
    @(negedge clk); uart_tx_rdy = 1'b0;
    wr(8'hC0, 8'h00);

    // R6 loopback order
    wr(8'hC0, 8'hF3);
    push_out(8'h11); push_out(8'h22); push_out(8'h33);
    push_out(8'h44); push_out(8'h55);
    rd(8'hC0, v);
    check("R3 in empty", {7'b0, v[3]}, 8'h01);
    repeat (5) tick();
    rd(8'hC0, v);
    check("R3 in ready", {7'b0, v[3]}, 8'h00);
    repeat (5) pop_in("R6 loop order");
    rd(8'hC0, v);
    check("R3 in drained", {7'b0, v[3]}, 8'h01);

    // R6 frame sync gate
    wr(8'hC0, 8'hD3);
    push_out(8'h66);
    tick();
    rd(8'hC0, v);
    check("R6 no move without frame sync", {7'b0, v[3]}, 8'h01);
    wr(8'hC0, 8'hF3);
    tick();
    pop_in("R6 after frame sync");

    // R5 overflow, R11 empty read
    for (int i = 0; i < 16; i++) push_out(8'(i * 7 + 1));
    wr(8'hC1, 8'hEE);
    rd(8'hC0, v);
    check("R3 out full", {7'b0, v[2]}, 8'h01);
    repeat (18) tick();
    for (int i = 0; i < 16; i++) pop_in("R5 overflow dropped");
    rd(8'hC1, v);
    check("R11 empty read", v, 8'h00);
    rd(8'hC0, v);
    check("R3 out room", {7'b0, v[2]}, 8'h00);

    // R7 codec path
    wr(8'hC0, 8'h00);
    wr(8'hC0, 8'hE0);
    push_out(8'hA1); push_out(8'hB2); push_out(8'hC3);
    repeat (3) tick();
    check("R7 all sent", 8'(exp_q.size()), 8'h00);
    @(negedge clk); spk_in_vld = 1'b1; spk_in_data = 8'h5A;
    @(negedge clk); spk_in_vld = 1'b0;
    rd(8'hC1, v);
    check("R7 codec in", v, 8'h5A);

    // R5 write dropped while speech-out disabled
    wr(8'hC0, 8'hA0);
    begin
      int seen0;
      seen0 = out_seen;
      wr(8'hC1, 8'h77);
      wr(8'hC0, 8'hE0);
      tick();
      check("R5 disabled write dropped", 8'(out_seen - seen0), 8'h00);
    end

    // R8 / R9 FIFO source
    wr(8'hC0, 8'h00);
    wr(8'hC0, 8'hE3);
    @(negedge clk);
    check("R8 fifo irq", {7'b0, irq_n}, 8'h00);
    wr(8'hC3, 8'h00);
    check("R9 ack release", {7'b0, irq_n}, 8'h01);
    repeat (3) @(negedge clk);
    check("R9 stays released", {7'b0, irq_n}, 8'h01);

    // R8 / R9 serial source
    wr(8'hC0, 8'h00);
    wr(8'hC0, 8'h80);
    @(negedge clk); uart_rx_rdy = 1'b1;
    @(negedge clk);
    check("R8 serial irq", {7'b0, irq_n}, 8'h00);
    uart_rx_rdy = 1'b0;
    @(negedge clk);
    check("R9 level gone", {7'b0, irq_n}, 8'h01);

    // R8 / R9 DMA source
    wr(8'hC0, 8'h82);
    @(negedge clk); dma_done = 1'b1;
    @(negedge clk); dma_done = 1'b0;
    check("R8 dma irq", {7'b0, irq_n}, 8'h00);
    repeat (4) @(negedge clk);
    check("R9 dma held", {7'b0, irq_n}, 8'h00);
    wr(8'hC3, 8'h00);
    check("R9 dma ack", {7'b0, irq_n}, 8'h01);

    // R10 controller reset strobe
    wr(8'hC0, 8'hF3);
    push_out(8'h01); push_out(8'h02); push_out(8'h03);
    repeat (2) tick();
    wr(8'hC2, 8'h5C);
    exp_q.delete();
    rd(8'hC0, v);
    check("R10 reset strobe status", v, exp_status(8'h00, 0, 0, 0, 1));
    check("R10 reset strobe irq", {7'b0, irq_n}, 8'h01);

    // R10 zero control write
    wr(8'hC0, 8'hF3);
    push_out(8'h09); push_out(8'h0A);
    tick();
    wr(8'hC0, 8'h00);
    exp_q.delete();
    rd(8'hC0, v);
    check("R10 zero ctrl status", v, exp_status(8'h00, 0, 0, 0, 1));
    check("R10 zero ctrl irq", {7'b0, irq_n}, 8'h01);

    finish_run();
  end

endmodule